// File: doc/BRIEF.md
# Periodic Force Write-Back Scanner

This block holds the per-line bookkeeping a cache controller needs to push dirty persistent data out to the next memory level on a fixed schedule, without waiting for transaction boundaries. Each line of a small tag array carries a valid bit, a dirty bit and a force-mark bit. A scan pass starts after a programmable number of idle cycles and walks the array. Dirty lines found unmarked are marked. Lines found still marked and still dirty on the following pass get a forced write-back request.

Any line cleaned by an ordinary eviction between two passes loses its mark, so it never costs a forced write-back. The interval is meant to be set from the size of the recovery log and the peak write bandwidth of the nonvolatile memory, so that data is forced out before its log records can be overwritten. The busy output stays high for the whole pass, including any write-back still waiting for its acknowledge. A context switch can hold off on it until every forced write-back has completed.

Top module: `fwb_scanner`

## Requirements
- R1: After reset every line is clean and unmarked, `wb_req` and `busy` are 0, and the first pass issues no write-back.
- R2: A write sets the line's dirty and valid bits.
- R3: A line visited while clean, {mark,dirty} = 2'b00, is left unchanged and produces no request.
- R4: A line visited while dirty and unmarked, 2'b01, gets its mark set and produces no request on that visit.
- R5: A line visited while marked and dirty, 2'b11, raises `wb_req` with `wb_idx` equal to its index. The request is held with a stable index until `wb_ack` is sampled high. The line then returns to 2'b00, so later passes issue no request for it.
- R6: An eviction clears the line's dirty, mark and valid bits, so a line evicted after being marked gets no forced write-back.
- R7: With `scan_interval` = V > 0, a pass starts at the clock edge that completes V idle cycles since reset or since the previous pass ended. `busy` is high after that edge. V = 0 starts no pass, but the idle count keeps running. If V is later raised to a value at or below the count, a pass starts at the next edge.
- R8: A pass visits lines in ascending index order, one per cycle. It pauses on a forced line until the acknowledge, so a pass lasts NUM_LINES cycles plus one extra cycle per forced line beyond its acknowledge wait.
- R9: `busy` is high exactly while a pass is in progress, and `wb_req` is never high while `busy` is low.
- R10: A write that reaches a line while its forced write-back is outstanding, including the cycle the request is issued, leaves the line dirty and unmarked after the acknowledge. The next pass marks it and the pass after forces it.
- R11: `wb_ack` while no request is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A store updates a line this cycle |
| wr_idx | input | IDX_W | Index of the written line |
| evict_valid | input | 1 | A line is evicted or written back normally this cycle |
| evict_idx | input | IDX_W | Index of the evicted line |
| scan_interval | input | INTERVAL_W | Idle cycles between passes; 0 disables scanning |
| wb_ack | input | 1 | Next level has accepted the forced write-back |
| wb_req | output | 1 | Forced write-back request |
| wb_idx | output | IDX_W | Line index of the forced write-back |
| busy | output | 1 | A scan pass, including any outstanding forced write-back, is in progress |

## Verification
The bench builds the block with eight lines and an 8-bit interval, so each pass is short. Every line can be taken through the full clean, marked, forced cycle several times within a few hundred clocks. Acknowledge latency is varied between zero and three cycles, which makes room to land a write on a line while its forced write-back is outstanding. A zero interval is used to show that scanning stops while the idle count keeps running.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  // {mark, dirty} encoding of one line
  typedef enum logic [1:0] {
    LN_CLEAN  = 2'b00,
    LN_DIRTY  = 2'b01,
    LN_MARKED = 2'b11
  } line_state_e;

  function automatic line_state_e line_state(input logic mark, input logic dirty);
    if (!dirty)    return LN_CLEAN;
    else if (mark) return LN_MARKED;
    else           return LN_DIRTY;
  endfunction
endpackage

// File: rtl/fwb_interval_timer.sv
module fwb_interval_timer #(
  parameter int INTERVAL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  idle,
  input  logic [INTERVAL_W-1:0] interval,
  output logic                  start
);
  localparam logic [INTERVAL_W-1:0] CNT_MAX = '1;

  logic [INTERVAL_W-1:0] cnt_q;

  assign start = idle && (interval != '0) && (cnt_q >= interval - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!idle || start) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (interval == '0) |-> !start);
endmodule

// File: rtl/fwb_line_array.sv
module fwb_line_array #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 ev_en,
  input  logic [IDX_W-1:0]     ev_idx,
  input  logic                 mark_en,
  input  logic [IDX_W-1:0]     mark_idx,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 clr_keep,
  output logic [NUM_LINES-1:0] dirty_vec,
  output logic [NUM_LINES-1:0] mark_vec,
  output logic [NUM_LINES-1:0] valid_vec
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic d_q, m_q, v_q;
    logic d_n, m_n, v_n;

    // Update order: scan mark, post-ack clear, eviction, write.
    always_comb begin
      d_n = d_q;
      m_n = m_q;
      v_n = v_q;
      if (mark_en && mark_idx == IDX_W'(i)) m_n = 1'b1;
      if (clr_en && clr_idx == IDX_W'(i)) begin
        m_n = 1'b0;
        d_n = clr_keep;
      end
      if (ev_en && ev_idx == IDX_W'(i)) begin
        m_n = 1'b0;
        d_n = 1'b0;
        v_n = 1'b0;
      end
      if (wr_en && wr_idx == IDX_W'(i)) begin
        d_n = 1'b1;
        v_n = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        d_q <= 1'b0;
        m_q <= 1'b0;
        v_q <= 1'b0;
      end else begin
        d_q <= d_n;
        m_q <= m_n;
        v_q <= v_n;
      end
    end

    assign dirty_vec[i] = d_q;
    assign mark_vec[i]  = m_q;
    assign valid_vec[i] = v_q;
  end

  // R4
  mark_needs_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_vec & ~dirty_vec) == '0);

  // R2
  write_sets_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (dirty_vec[$past(wr_idx)] && valid_vec[$past(wr_idx)]));

  // R6
  evict_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_en && !(wr_en && wr_idx == ev_idx)) |=>
      (!dirty_vec[$past(ev_idx)] && !mark_vec[$past(ev_idx)]));
endmodule

// File: rtl/fwb_scan_ctrl.sv
module fwb_scan_ctrl
  import fwb_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NUM_LINES-1:0] dirty_vec,
  input  logic [NUM_LINES-1:0] mark_vec,
  input  logic [NUM_LINES-1:0] valid_vec,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wb_ack,
  output logic                 mark_en,
  output logic [IDX_W-1:0]     mark_idx,
  output logic                 clr_en,
  output logic [IDX_W-1:0]     clr_idx,
  output logic                 clr_keep,
  output logic                 wb_req,
  output logic [IDX_W-1:0]     wb_idx,
  output logic                 scanning
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

  logic             waiting_q, redirty_q;
  logic [IDX_W-1:0] ptr_q;
  line_state_e      cur;
  logic             visit, force_now, ack_now, advance;

  assign cur       = line_state(mark_vec[ptr_q], dirty_vec[ptr_q] & valid_vec[ptr_q]);
  assign visit     = scanning && !waiting_q;
  assign force_now = visit && (cur == LN_MARKED);
  assign ack_now   = waiting_q && wb_ack;
  assign advance   = (visit && !force_now) || ack_now;

  assign mark_en   = visit && (cur == LN_DIRTY);
  assign mark_idx  = ptr_q;
  assign clr_en    = ack_now;
  assign clr_idx   = wb_idx;
  assign clr_keep  = redirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scanning  <= 1'b0;
      waiting_q <= 1'b0;
      redirty_q <= 1'b0;
      ptr_q     <= '0;
      wb_req    <= 1'b0;
      wb_idx    <= '0;
    end else begin
      if (start) begin
        scanning <= 1'b1;
        ptr_q    <= '0;
      end else if (advance) begin
        if (ptr_q == LAST) scanning <= 1'b0;
        else               ptr_q    <= ptr_q + 1'b1;
      end

      if (force_now) begin
        wb_req    <= 1'b1;
        wb_idx    <= ptr_q;
        waiting_q <= 1'b1;
      end else if (ack_now) begin
        wb_req    <= 1'b0;
        waiting_q <= 1'b0;
      end

      if (force_now)
        redirty_q <= wr_en && (wr_idx == ptr_q);
      else if (waiting_q && !wb_ack && wr_en && (wr_idx == wb_idx))
        redirty_q <= 1'b1;
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

  // R5
  req_from_marked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_req) |-> ($past(mark_vec[ptr_q]) && $past(dirty_vec[ptr_q])));

  // R9
  req_within_pass_chk: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> scanning);
endmodule

// File: rtl/fwb_scanner.sv
module fwb_scanner #(
  parameter int NUM_LINES  = 16,
  parameter int INTERVAL_W = 16,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_valid,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  evict_valid,
  input  logic [IDX_W-1:0]      evict_idx,
  input  logic [INTERVAL_W-1:0] scan_interval,
  input  logic                  wb_ack,
  output logic                  wb_req,
  output logic [IDX_W-1:0]      wb_idx,
  output logic                  busy
);
  logic                 start, scanning;
  logic                 mark_en, clr_en, clr_keep;
  logic [IDX_W-1:0]     mark_idx, clr_idx;
  logic [NUM_LINES-1:0] dirty_vec, mark_vec, valid_vec;

  fwb_interval_timer #(.INTERVAL_W(INTERVAL_W)) timer_i (
    .clk(clk), .rst(rst), .idle(!scanning), .interval(scan_interval), .start(start)
  );

  fwb_line_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) lines_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_valid), .wr_idx(wr_idx),
    .ev_en(evict_valid), .ev_idx(evict_idx),
    .mark_en(mark_en), .mark_idx(mark_idx),
    .clr_en(clr_en), .clr_idx(clr_idx), .clr_keep(clr_keep),
    .dirty_vec(dirty_vec), .mark_vec(mark_vec), .valid_vec(valid_vec)
  );

  fwb_scan_ctrl #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .dirty_vec(dirty_vec), .mark_vec(mark_vec), .valid_vec(valid_vec),
    .wr_en(wr_valid), .wr_idx(wr_idx), .wb_ack(wb_ack),
    .mark_en(mark_en), .mark_idx(mark_idx),
    .clr_en(clr_en), .clr_idx(clr_idx), .clr_keep(clr_keep),
    .wb_req(wb_req), .wb_idx(wb_idx), .scanning(scanning)
  );

  assign busy = scanning;
endmodule

// File: tb/fwb_scanner_tb_top.sv
module fwb_scanner_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0, evict_valid = 1'b0, wb_ack = 1'b0;
  logic [IW-1:0] wr_idx = '0, evict_idx = '0;
  logic [TW-1:0] scan_interval = 8'd5;
  logic          wb_req, busy;
  logic [IW-1:0] wb_idx;

  always #4 clk = ~clk;

  fwb_scanner #(.NUM_LINES(N), .INTERVAL_W(TW)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .scan_interval(scan_interval), .wb_ack(wb_ack),
    .wb_req(wb_req), .wb_idx(wb_idx), .busy(busy)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_d[N], m_f[N];
  int m_scan, m_wait, m_ptr, m_req, m_idx, m_red, m_cnt;

  always @(posedge clk) begin
    int p; bit mk, cl, fz, adv, st; int keep;
    if (rst) begin
      foreach (m_d[k]) begin m_d[k] = 0; m_f[k] = 0; end
      m_scan = 0; m_wait = 0; m_ptr = 0; m_req = 0; m_idx = 0; m_red = 0; m_cnt = 0;
    end else begin
      p = m_ptr; mk = 0; cl = 0; fz = 0; adv = 0; st = 0; keep = m_red;
      if (!m_scan) begin
        if (scan_interval != 0 && m_cnt + 1 >= int'(scan_interval)) st = 1;
      end else if (!m_wait) begin
        if (m_d[p] == 0) adv = 1;
        else if (m_f[p] == 0) begin mk = 1; adv = 1; end
        else fz = 1;
      end else if (wb_ack) begin
        cl = 1; adv = 1;
      end
      if (m_scan || st) m_cnt = 0; else if (m_cnt < 255) m_cnt++;
      if (mk) m_f[p] = 1;
      if (cl) begin m_f[m_idx] = 0; m_d[m_idx] = keep; end
      if (evict_valid) begin m_f[evict_idx] = 0; m_d[evict_idx] = 0; end
      if (wr_valid) m_d[wr_idx] = 1;
      if (fz) m_red = (wr_valid && int'(wr_idx) == p) ? 1 : 0;
      else if (m_wait && !wb_ack && wr_valid && int'(wr_idx) == m_idx) m_red = 1;
      if (st) begin m_scan = 1; m_ptr = 0; end
      else if (adv) begin
        if (p == N - 1) m_scan = 0; else m_ptr = p + 1;
      end
      if (fz) begin m_req = 1; m_idx = p; m_wait = 1; end
      else if (cl) begin m_req = 0; m_wait = 0; end
    end
  end

  // Acknowledge responder and pass bookkeeping
  int  ack_lat = 0, ack_cnt = 0;
  bit  stray_ack = 0;
  int  redirty_tgt = -1;
  bit  inj_done = 0;
  bit  prev_req = 0;
  int  pass_q[$];
  int  pass_len, wait_n;

  task automatic tick();
    @(posedge clk); #1;
    // R9 busy, R5 request, R8 index against the model every cycle
    chk(busy == m_scan[0], "R9 busy", busy, m_scan);
    chk(wb_req == m_req[0], "R5 wb_req", wb_req, m_req);
    if (m_req != 0) chk(int'(wb_idx) == m_idx, "R8 wb_idx", wb_idx, m_idx);
    if (wb_req && !prev_req) pass_q.push_back(int'(wb_idx));
    prev_req = wb_req;
    wr_valid = 0; evict_valid = 0; wb_ack = 0;
    if (wb_req) begin
      if (ack_cnt >= ack_lat) begin wb_ack = 1; ack_cnt = 0; end
      else ack_cnt++;
    end else begin
      ack_cnt = 0;
      if (stray_ack) wb_ack = 1;
    end
    if (redirty_tgt >= 0 && !inj_done && wb_req && int'(wb_idx) == redirty_tgt) begin
      wr_valid = 1; wr_idx = IW'(redirty_tgt); inj_done = 1;
    end
  endtask

  task automatic finish_pass();
    pass_len = 0;
    while (busy) begin tick(); pass_len++; end
  endtask

  task automatic next_pass();
    pass_q.delete();
    wait_n = 0;
    while (!busy) begin tick(); wait_n++; end
    finish_pass();
  endtask

  task automatic do_write(input int idx);
    wr_valid = 1; wr_idx = IW'(idx); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk(wb_req == 0, "R1 wb_req at reset", wb_req, 0);
    chk(busy == 0, "R1 busy at reset", busy, 0);
    n = 0;
    while (!busy) begin tick(); n++; end
    chk(n == 5, "R7 first pass start", n, 5);
    pass_q.delete();
    finish_pass();
    chk(pass_q.size() == 0, "R1 R3 no request on clean array", pass_q.size(), 0);
    chk(pass_len == N, "R8 clean pass length", pass_len, N);

    // R2 R4 R5: writes, mark pass, force pass, quiet pass
    do_write(3); do_write(6);
    next_pass();
    chk(wait_n == 3, "R7 idle gap after writes", wait_n, 3);
    chk(pass_q.size() == 0, "R4 marking pass is quiet", pass_q.size(), 0);
    next_pass();
    chk(wait_n == 5, "R7 idle gap between passes", wait_n, 5);
    chk(pass_q.size() == 2, "R2 R5 forced count", pass_q.size(), 2);
    if (pass_q.size() == 2) begin
      chk(pass_q[0] == 3, "R8 first forced index", pass_q[0], 3);
      chk(pass_q[1] == 6, "R8 second forced index", pass_q[1], 6);
    end
    chk(pass_len == N + 2, "R8 pass length with two forces", pass_len, N + 2);
    next_pass();
    chk(pass_q.size() == 0, "R5 forced lines return clean", pass_q.size(), 0);

    // R6 eviction of a marked line
    do_write(2);
    next_pass();
    chk(pass_q.size() == 0, "R4 mark line 2", pass_q.size(), 0);
    evict_valid = 1; evict_idx = 3'd2; tick();
    next_pass();
    chk(pass_q.size() == 0, "R6 evicted line not forced", pass_q.size(), 0);

    // R10 write during an outstanding forced write-back
    do_write(4);
    next_pass();
    ack_lat = 3; redirty_tgt = 4; inj_done = 0;
    next_pass();
    chk(pass_q.size() == 1 && pass_q[0] == 4, "R10 line 4 forced", pass_q.size(), 1);
    chk(pass_len == N + 4, "R8 pass length with slow ack", pass_len, N + 4);
    redirty_tgt = -1; ack_lat = 0;
    next_pass();
    chk(pass_q.size() == 0, "R10 rewritten line only marked", pass_q.size(), 0);
    next_pass();
    chk(pass_q.size() == 1 && pass_q[0] == 4, "R10 rewritten line forced again", pass_q.size(), 1);
    next_pass();
    chk(pass_q.size() == 0, "R10 line clean afterwards", pass_q.size(), 0);

    // R11 stray acknowledges
    stray_ack = 1;
    next_pass();
    chk(pass_q.size() == 0, "R11 stray ack on clean array", pass_q.size(), 0);
    do_write(5);
    next_pass();
    chk(pass_q.size() == 0, "R11 stray ack during mark pass", pass_q.size(), 0);
    next_pass();
    chk(pass_q.size() == 1 && pass_q[0] == 5, "R11 force still issued", pass_q.size(), 1);
    stray_ack = 0;

    // R7 zero interval disables scanning
    scan_interval = 8'd0;
    n = 0;
    for (int k = 0; k < 40; k++) begin tick(); if (busy) n++; end
    chk(n == 0, "R7 zero interval no pass", n, 0);
    scan_interval = 8'd3;
    n = 0;
    while (!busy) begin tick(); n++; end
    chk(n == 1, "R7 overdue interval starts at once", n, 1);
    finish_pass();

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule